// File: doc/BRIEF.md
# Multiplexed Burst Bus Controller

This block sits between a 32-bit core and an external 16-bit bus on which the address and the data share the same wires. The core hands it one request at a time: a start address, a byte count from 1 to 16, a write flag, and for writes up to 16 bytes of data. Byte k of the request is held in bits 8k+7..8k of the data word. The controller turns each request into one or two bus accesses. Each access is an address phase, then one data beat per halfword, then a recovery phase. A slave holds off any beat by keeping ready low.

The controller runs through five named states. IDLE waits for a request. ADDR is the single address phase, with the strobe and the latch enable high and the halfword address on the shared bus. DATA is the first cycle of a beat. WAIT is every further cycle of a beat that ready has not yet released. RECOVER turns the bus around after the final beat of an access. The transitions are:

- IDLE to ADDR when a valid request is accepted.
- ADDR to DATA always.
- DATA or WAIT to WAIT when ready is low.
- DATA or WAIT to DATA when ready is high and the beat was not the last of its access.
- DATA or WAIT to RECOVER when ready is high on the last beat of its access.
- RECOVER to ADDR when the request still has bytes left.
- RECOVER to IDLE otherwise, with done pulsed during that RECOVER cycle.

Inside an access, the three address bits above the byte bit (A3..A1) count up by one per beat. An access never crosses a 16-byte block. A request that spills over a block boundary therefore becomes two accesses.

Top module: `mbb_ctrl`

## Requirements
- R1: After reset, and while idle, bus_as, bus_ale, bus_den, bus_dir_tx, bus_blast, bus_ad_oe, bus_wr and req_busy are low, and bus_be is 00.
- R2: A request accepted at a clock edge puts the controller in ADDR for exactly the next cycle. In ADDR, bus_as and bus_ale are high, bus_ad_o carries address bits 15..1 with bit 0 zero, bus_addr_hi carries address bits 31..16, and bus_a_low carries A3..A1 of the first halfword.
- R3: bus_den is high in every data cycle. A beat completes only at an edge where bus_ready is high. Each data cycle with bus_ready low adds one wait cycle, and bus_a_low and bus_be hold steady through it. bus_ready is ignored outside data cycles.
- R4: bus_a_low increases by one after each completed beat of an access. The upper address bits stay fixed within the access.
- R5: bus_blast is high during the final beat of every access. The final beat is either the request's last halfword or the halfword whose A3..A1 equals 111.
- R6: bus_be[0] enables the even-address byte (bits 7..0) and bus_be[1] enables the odd-address byte (bits 15..8). On the first beat, bit 0 is clear when the start address is odd. On the last beat, bit 1 is clear when the last byte's address is even. All other beats enable both bytes.
- R7: A request whose bytes span two 16-byte blocks is carried out as two accesses, with RECOVER between them. The second access starts at the next block with A3..A1 = 000.
- R8: A one-halfword request with no wait cycles takes three cycles: ADDR, DATA, RECOVER. req_done is high in the RECOVER cycle that ends the request.
- R9: For writes, bus_wr and bus_dir_tx are high from ADDR through the final RECOVER. For reads they stay low. bus_den is never high in ADDR or RECOVER, so the direction only changes while the data enable is off.
- R10: On writes, the byte for address start+k is taken from req_wdata bits 8k+7..8k and driven on the lane its address selects. On reads, the byte taken from that lane at the beat's completing edge is placed in req_rdata bits 8k+7..8k, where it stays until the next accepted request.
- R11: req_start is ignored while busy, or when req_nbytes is 0 or greater than 16. Ignored means no address phase follows and the controller stays or returns idle as before.
- R12: bus_ad_oe is high in ADDR and in write data cycles. It is low in read data cycles, RECOVER and IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start | input | 1 | Request strobe, taken only when idle |
| req_addr | input | 32 | Byte address of the first byte |
| req_nbytes | input | 5 | Byte count, 1 to 16 |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 128 | Write bytes, byte k in bits 8k+7..8k |
| req_busy | output | 1 | High whenever not idle |
| req_done | output | 1 | One-cycle pulse in the final RECOVER |
| req_rdata | output | 128 | Read bytes, byte k in bits 8k+7..8k |
| bus_ready | input | 1 | Slave ready, sampled in data cycles |
| bus_ad_i | input | 16 | Read data from the shared bus |
| bus_ad_o | output | 16 | Address in ADDR, write data in data cycles |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_o |
| bus_addr_hi | output | 16 | Address bits 31..16 |
| bus_a_low | output | 3 | Halfword index A3..A1 within the block |
| bus_be | output | 2 | Byte lane enables (odd, even) |
| bus_as | output | 1 | Address strobe |
| bus_ale | output | 1 | Address latch enable |
| bus_wr | output | 1 | Write (1) or read (0) |
| bus_dir_tx | output | 1 | Transceiver direction, 1 = outbound |
| bus_den | output | 1 | Data enable |
| bus_blast | output | 1 | Final beat of the access |

## Verification
A request strobed before a rising edge shows its address phase in the very next cycle. Each beat is resolved at the edge that samples ready high. The next beat, or RECOVER with its done pulse, is visible in the cycle after that edge.

The bench samples every output at the falling edge of the cycle in which it is valid and sets ready and read data at that same falling edge. The value set there is the one the next rising edge takes. Elapsed cycles from the first address phase to done must therefore equal two per access, plus one per beat, plus every stall the bench itself inserted, minus one.

// File: rtl/mbb_pkg.sv
package mbb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ADDR    = 3'd1,
        ST_DATA    = 3'd2,
        ST_WAIT    = 3'd3,
        ST_RECOVER = 3'd4
    } bstate_e;

endpackage

// File: rtl/mbb_fsm.sv
module mbb_fsm
    import mbb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    accept,
    input  logic    ready,
    input  logic    acc_last,
    input  logic    more_left,
    output bstate_e state
);

    bstate_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    nxt = accept ? ST_ADDR : ST_IDLE;
            ST_ADDR:    nxt = ST_DATA;
            ST_DATA,
            ST_WAIT:    begin
                if (!ready)        nxt = ST_WAIT;
                else if (acc_last) nxt = ST_RECOVER;
                else               nxt = ST_DATA;
            end
            ST_RECOVER: nxt = more_left ? ST_ADDR : ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/mbb_addr_gen.sv
module mbb_addr_gen #(
    parameter int ADDR_W    = 32,
    parameter int MAX_BYTES = 16,
    localparam int NB_W = $clog2(MAX_BYTES) + 1,
    localparam int BI_W = $clog2(MAX_BYTES / 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NB_W-1:0]   nbytes,
    input  logic              beat_done,
    output logic [ADDR_W-2:0] cur_hw,
    output logic              acc_last,
    output logic              txn_last,
    output logic [1:0]        be,
    output logic [NB_W-1:0]   rel_off,
    output logic              more_left
);

    logic [ADDR_W-2:0] end_hw;
    logic [NB_W-1:0]   start_lo;
    logic              start_odd;
    logic              end_odd;
    logic              first_beat;
    logic [ADDR_W-1:0] end_byte;

    assign end_byte = addr + ADDR_W'(nbytes) - ADDR_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_hw     <= '0;
            end_hw     <= '0;
            start_lo   <= '0;
            start_odd  <= 1'b0;
            end_odd    <= 1'b0;
            first_beat <= 1'b0;
            more_left  <= 1'b0;
        end else if (load) begin
            cur_hw     <= addr[ADDR_W-1:1];
            end_hw     <= end_byte[ADDR_W-1:1];
            start_lo   <= addr[NB_W-1:0];
            start_odd  <= addr[0];
            end_odd    <= end_byte[0];
            first_beat <= 1'b1;
            more_left  <= 1'b1;
        end else if (beat_done) begin
            cur_hw     <= cur_hw + 1'b1;
            first_beat <= 1'b0;
            if (txn_last) more_left <= 1'b0;
        end
    end

    // the access closes at the end of the request or at the top of a block
    assign txn_last = (cur_hw == end_hw);
    assign acc_last = txn_last || (&cur_hw[BI_W-1:0]);
    assign be[0]    = !(first_beat && start_odd);
    assign be[1]    = !(txn_last && !end_odd);
    assign rel_off  = {cur_hw[NB_W-2:0], 1'b0} - start_lo;

endmodule

// File: rtl/mbb_datapath.sv
module mbb_datapath #(
    parameter int MAX_BYTES = 16,
    localparam int NB_W = $clog2(MAX_BYTES) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   capture,
    input  logic [8*MAX_BYTES-1:0] wdata,
    input  logic [NB_W-1:0]        rel_off,
    input  logic [1:0]             be,
    input  logic [15:0]            rd_half,
    output logic [15:0]            wr_half,
    output logic [8*MAX_BYTES-1:0] rdata
);

    logic [NB_W-1:0] off_hi;
    logic [7:0]      lane0;
    logic [7:0]      lane1;
    logic [7:0]      rbyte [MAX_BYTES];

    assign off_hi = rel_off + NB_W'(1);

    always_comb begin
        lane0 = 8'h00;
        lane1 = 8'h00;
        for (int i = 0; i < MAX_BYTES; i++) begin
            if (rel_off == NB_W'(i)) lane0 = wdata[8*i +: 8];
            if (off_hi  == NB_W'(i)) lane1 = wdata[8*i +: 8];
        end
        if (!be[0]) lane0 = 8'h00;
        if (!be[1]) lane1 = 8'h00;
    end

    assign wr_half = {lane1, lane0};

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_rbyte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rbyte[g] <= 8'h00;
            else if (load)
                rbyte[g] <= 8'h00;
            else if (capture && be[0] && rel_off == NB_W'(g))
                rbyte[g] <= rd_half[7:0];
            else if (capture && be[1] && off_hi == NB_W'(g))
                rbyte[g] <= rd_half[15:8];
        end
        assign rdata[8*g +: 8] = rbyte[g];
    end

endmodule

// File: rtl/mbb_ctrl.sv
module mbb_ctrl
    import mbb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_BYTES = 16,
    localparam int NB_W = $clog2(MAX_BYTES) + 1,
    localparam int BI_W = $clog2(MAX_BYTES / 2)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_start,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [NB_W-1:0]        req_nbytes,
    input  logic                   req_wr,
    input  logic [8*MAX_BYTES-1:0] req_wdata,
    output logic                   req_busy,
    output logic                   req_done,
    output logic [8*MAX_BYTES-1:0] req_rdata,
    input  logic                   bus_ready,
    input  logic [15:0]            bus_ad_i,
    output logic [15:0]            bus_ad_o,
    output logic                   bus_ad_oe,
    output logic [ADDR_W-17:0]     bus_addr_hi,
    output logic [BI_W-1:0]        bus_a_low,
    output logic [1:0]             bus_be,
    output logic                   bus_as,
    output logic                   bus_ale,
    output logic                   bus_wr,
    output logic                   bus_dir_tx,
    output logic                   bus_den,
    output logic                   bus_blast
);

    bstate_e           state;
    logic              accept;
    logic              in_data;
    logic              beat_done;
    logic              acc_last;
    logic              txn_last;
    logic              more_left;
    logic              wr_q;
    logic [ADDR_W-2:0] cur_hw;
    logic [1:0]        be;
    logic [NB_W-1:0]   rel_off;
    logic [15:0]       wr_half;

    assign accept    = req_start && (state == ST_IDLE) &&
                       (req_nbytes != '0) && (req_nbytes <= NB_W'(MAX_BYTES));
    assign in_data   = (state == ST_DATA) || (state == ST_WAIT);
    assign beat_done = in_data && bus_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      wr_q <= 1'b0;
        else if (accept) wr_q <= req_wr;
    end

    mbb_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .ready     (bus_ready),
        .acc_last  (acc_last),
        .more_left (more_left),
        .state     (state)
    );

    mbb_addr_gen #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .addr      (req_addr),
        .nbytes    (req_nbytes),
        .beat_done (beat_done),
        .cur_hw    (cur_hw),
        .acc_last  (acc_last),
        .txn_last  (txn_last),
        .be        (be),
        .rel_off   (rel_off),
        .more_left (more_left)
    );

    mbb_datapath #(.MAX_BYTES(MAX_BYTES)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .capture (beat_done && !wr_q),
        .wdata   (req_wdata),
        .rel_off (rel_off),
        .be      (be),
        .rd_half (bus_ad_i),
        .wr_half (wr_half),
        .rdata   (req_rdata)
    );

    assign bus_addr_hi = cur_hw[ADDR_W-2:15];
    assign bus_a_low   = cur_hw[BI_W-1:0];

    always_comb begin
        req_busy   = 1'b1;
        req_done   = 1'b0;
        bus_as     = 1'b0;
        bus_ale    = 1'b0;
        bus_den    = 1'b0;
        bus_blast  = 1'b0;
        bus_ad_o   = 16'h0000;
        bus_ad_oe  = 1'b0;
        bus_wr     = wr_q;
        bus_dir_tx = wr_q;
        bus_be     = be;
        unique case (state)
            ST_IDLE: begin
                req_busy   = 1'b0;
                bus_wr     = 1'b0;
                bus_dir_tx = 1'b0;
                bus_be     = 2'b00;
            end
            ST_ADDR: begin
                bus_as    = 1'b1;
                bus_ale   = 1'b1;
                bus_ad_o  = {cur_hw[14:0], 1'b0};
                bus_ad_oe = 1'b1;
            end
            ST_DATA,
            ST_WAIT: begin
                bus_den   = 1'b1;
                bus_blast = acc_last;
                bus_ad_o  = wr_q ? wr_half : 16'h0000;
                bus_ad_oe = wr_q;
            end
            ST_RECOVER: begin
                req_done = !more_left;
            end
            default: begin
                req_busy = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/mbb_ctrl_chk.sv
module mbb_ctrl_chk #(
    parameter int MAX_BYTES = 16,
    localparam int BI_W = $clog2(MAX_BYTES / 2)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_busy,
    input logic            bus_as,
    input logic            bus_den,
    input logic            bus_ready,
    input logic            bus_blast,
    input logic            bus_wr,
    input logic            bus_dir_tx,
    input logic            bus_ad_oe,
    input logic [BI_W-1:0] bus_a_low,
    input logic [1:0]      bus_be
);

    a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as |=> !bus_as);

    a_r2_strobe_then_data: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as |=> bus_den);

    a_r9_no_den_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as |-> !bus_den);

    a_r9_dir_steady_den_on: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_den) |-> $stable(bus_dir_tx));

    a_r9_dir_steady_den_off: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_den) |-> $stable(bus_dir_tx));

    a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_den && !bus_ready) |=> (bus_den && $stable(bus_a_low) && $stable(bus_be)));

    a_r4_low_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_den && bus_ready && !bus_blast) |=>
            (bus_den && bus_a_low == $past(bus_a_low) + BI_W'(1)));

    a_r5_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_den && bus_ready && bus_blast) |=> !bus_den);

    a_r12_read_floats: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_den && !bus_wr) |-> !bus_ad_oe);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_busy |-> (!bus_as && !bus_den));

endmodule

bind mbb_ctrl mbb_ctrl_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_busy   (req_busy),
    .bus_as     (bus_as),
    .bus_den    (bus_den),
    .bus_ready  (bus_ready),
    .bus_blast  (bus_blast),
    .bus_wr     (bus_wr),
    .bus_dir_tx (bus_dir_tx),
    .bus_ad_oe  (bus_ad_oe),
    .bus_a_low  (bus_a_low),
    .bus_be     (bus_be)
);

// File: tb/tb_mbb_ctrl.sv
module tb_mbb_ctrl;

    localparam logic [31:0] BASE = 32'h4A5C_1200;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_start = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [4:0]   req_nbytes = '0;
    logic         req_wr = 1'b0;
    logic [127:0] req_wdata = '0;
    logic         req_busy, req_done;
    logic [127:0] req_rdata;
    logic         bus_ready = 1'b0;
    logic [15:0]  bus_ad_i = '0;
    logic [15:0]  bus_ad_o;
    logic         bus_ad_oe;
    logic [15:0]  bus_addr_hi;
    logic [2:0]   bus_a_low;
    logic [1:0]   bus_be;
    logic         bus_as, bus_ale, bus_wr, bus_dir_tx, bus_den, bus_blast;

    mbb_ctrl dut (.*);

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0] mem    [256];
    logic [7:0] shadow [256];

    bit          cur_wr;
    logic [31:0] cur_start, cur_end, lat_addr;
    int          cur_n, nb, n_acc;
    int          beat_idx, waits_left, waits_total, seen_as;
    int          t_cycle, t_as, t_done, w_first, w_later;
    bit          in_beat;

    task automatic chk(input bit ok, input string rq, input longint unsigned act,
                       input longint unsigned exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_be(input int j);
        exp_be[0] = !(j == 0 && cur_start[0]);
        exp_be[1] = !(j == nb - 1 && !cur_end[0]);
    endfunction

    function automatic logic [30:0] exp_hw(input int j);
        return cur_start[31:1] + 31'(j);
    endfunction

    // one cycle of the slave model, called at a falling edge
    task automatic slave_step();
        logic [31:0] a;
        logic [30:0] h;
        bit          rdy;
        int          k;
        t_cycle++;
        rdy = 1'b0;
        bus_ad_i = 16'h0000;
        chk(bus_dir_tx == (req_busy && cur_wr) && bus_wr == bus_dir_tx,
            "R9 direction", {bus_dir_tx, bus_wr}, {2{req_busy && cur_wr}});
        if (bus_as) begin
            seen_as++;
            if (t_as < 0) t_as = t_cycle;
            h = exp_hw(beat_idx);
            chk({bus_addr_hi, bus_ad_o} == {h, 1'b0} && bus_a_low == h[2:0] && bus_ale,
                "R2 address phase", {bus_addr_hi, bus_ad_o}, {h, 1'b0});
            chk(bus_ad_oe && !bus_den, "R12 address drive", {bus_ad_oe, bus_den}, 2'b10);
            lat_addr = {bus_addr_hi, bus_ad_o};
        end
        if (bus_den) begin
            chk(bus_ad_oe == cur_wr, "R12 data drive", bus_ad_oe, cur_wr);
            if (!in_beat) begin
                in_beat = 1'b1;
                if (w_first < 0)        waits_left = $urandom_range(0, 3);
                else if (beat_idx == 0) waits_left = w_first;
                else                    waits_left = w_later;
            end
            a = {lat_addr[31:4], bus_a_low, 1'b0};
            bus_ad_i = {mem[a[7:0] + 8'd1], mem[a[7:0]]};
            if (waits_left > 0) begin
                waits_left--;
                waits_total++;
            end else begin
                rdy = 1'b1;
                in_beat = 1'b0;
                h = exp_hw(beat_idx);
                chk(a[31:1] == h && bus_addr_hi == lat_addr[31:16], "R4 beat address", a, {h, 1'b0});
                chk(bus_be == exp_be(beat_idx), "R6 byte enables", bus_be, exp_be(beat_idx));
                chk(bus_blast == (beat_idx == nb - 1 || h[2:0] == 3'b111), "R5 last beat",
                    bus_blast, (beat_idx == nb - 1 || h[2:0] == 3'b111));
                if (cur_wr) begin
                    k = int'(a - cur_start);
                    if (bus_be[0]) begin
                        chk(bus_ad_o[7:0] == req_wdata[8*k +: 8], "R10 write lane0",
                            bus_ad_o[7:0], req_wdata[8*k +: 8]);
                        mem[a[7:0]] = bus_ad_o[7:0];
                    end
                    if (bus_be[1]) begin
                        chk(bus_ad_o[15:8] == req_wdata[8*(k+1) +: 8], "R10 write lane1",
                            bus_ad_o[15:8], req_wdata[8*(k+1) +: 8]);
                        mem[a[7:0] + 8'd1] = bus_ad_o[15:8];
                    end
                end
                beat_idx++;
            end
        end
        if (req_done) t_done = t_cycle;
        bus_ready = rdy;
    endtask

    task automatic run_txn(input int off, input int n, input bit wr,
                           input int wf, input int wl, input bit poke);
        int dur;
        @(negedge clk);
        cur_wr = wr; cur_n = n;
        cur_start = BASE + 32'(off);
        cur_end   = cur_start + 32'(n) - 32'd1;
        nb    = int'(cur_end[31:1] - cur_start[31:1]) + 1;
        n_acc = (cur_start[31:4] != cur_end[31:4]) ? 2 : 1;
        w_first = wf; w_later = wl;
        beat_idx = 0; waits_left = 0; waits_total = 0; seen_as = 0;
        t_cycle = 0; t_as = -1; t_done = -1; in_beat = 1'b0;
        for (int i = 0; i < 4; i++) req_wdata[32*i +: 32] = $urandom;
        if (wr) for (int i = 0; i < n; i++) shadow[off + i] = req_wdata[8*i +: 8];
        req_addr = cur_start; req_nbytes = 5'(n); req_wr = wr; req_start = 1'b1;
        @(posedge clk);
        forever begin
            @(negedge clk);
            req_start = 1'b0;
            if (poke && t_cycle == 2) begin
                req_start = 1'b1;
                req_addr  = BASE + 32'h80;
            end
            slave_step();
            if (t_done >= 0 || t_cycle > 400) break;
            @(posedge clk);
        end
        req_start = 1'b0;
        chk(t_done >= 0, "R3 request completes", t_done, 1);
        chk(seen_as == n_acc, "R7 access count", seen_as, n_acc);
        chk(beat_idx == nb, "R4 beat count", beat_idx, nb);
        dur = t_done - t_as;
        if (nb == 1 && waits_total == 0)
            chk(dur == 2, "R8 zero-wait single transfer", dur, 2);
        else
            chk(dur == 2*n_acc + nb + waits_total - 1, "R3 wait insertion", dur,
                2*n_acc + nb + waits_total - 1);
        if (!wr) begin
            for (int i = 0; i < n; i++)
                chk(req_rdata[8*i +: 8] == mem[off + i], "R10 read byte",
                    req_rdata[8*i +: 8], mem[off + i]);
        end else begin
            bit same = 1'b1;
            for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) same = 1'b0;
            chk(same, "R10 memory after write", same, 1);
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!req_busy && !bus_as && !bus_den,
                poke ? "R11 start while busy ignored" : "R1 idle after request",
                {req_busy, bus_as, bus_den}, 0);
        end
    endtask

    task automatic bad_len(input int n);
        @(negedge clk);
        req_addr = BASE; req_nbytes = 5'(n); req_wr = 1'b0; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(!req_busy && !bus_as, "R11 bad length ignored", {req_busy, bus_as}, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        for (int i = 0; i < 256; i++) begin
            mem[i]    = 8'(i * 7 + 3);
            shadow[i] = mem[i];
        end
        cur_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk(!bus_as && !bus_ale && !bus_den && !bus_dir_tx && !bus_blast && !bus_ad_oe
            && !bus_wr && !req_busy && bus_be == 2'b00, "R1 reset state",
            {bus_as, bus_ale, bus_den, bus_dir_tx, bus_blast, bus_ad_oe, bus_wr, req_busy, bus_be}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_as && !req_busy, "R1 idle after release", {bus_as, req_busy}, 0);

        run_txn(8'h10, 2,  1'b0, 0, 0, 1'b0);  // R8 single halfword, no waits
        run_txn(8'h20, 8,  1'b1, 2, 1, 1'b0);  // R3 write with 2,1,1,1 stalls
        run_txn(8'h30, 16, 1'b0, 1, 0, 1'b0);  // R3 full read, 1 then 0
        run_txn(8'h45, 1,  1'b1, 0, 0, 1'b0);  // R6 odd single byte
        run_txn(8'h5B, 14, 1'b0, 0, 0, 1'b0);  // R7 crosses a block
        run_txn(8'h7F, 16, 1'b1, 1, 2, 1'b0);  // R7 write crossing, odd start
        run_txn(8'h90, 4,  1'b0, 3, 3, 1'b1);  // R11 start while busy
        bad_len(0);
        bad_len(17);
        for (int t = 0; t < 60; t++)
            run_txn($urandom_range(0, 239), $urandom_range(1, 16), 1'($urandom_range(0, 1)),
                    -1, -1, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule